// File: doc/BRIEF.md
# Sub-Dword Destination Merge Unit

This unit places a freshly computed 32-bit result into part of a lane's destination register. A 3-bit select code names the target: one of the four bytes, one of the two 16-bit halves, or the whole register. The bits outside the target come from an unused-bits policy. The policy can keep the old register contents, clear them, or sign-extend the written field upward while clearing the bits below it. An optional clamp first saturates the result to the unsigned range of the target field. The reserved select code raises an error flag and returns the current destination untouched.

The merge logic is combinational. It feeds one output register that loads when `in_en` is high. The merged word and the error flag therefore appear one clock after the inputs are presented, and they hold while `in_en` is low. Write enables and lane masking belong to the surrounding datapath.

Top module: `sdm_merge_unit`

## Requirements
- R1: For select codes 0 to 3, the byte at bits [8*sel+7 : 8*sel] of the output equals bits [7:0] of the (possibly clamped) new result.
- R2: In byte mode with unused format 2 (keep), every unselected byte equals the same byte of the current destination.
- R3: In byte mode with unused format 1 (sign-extend), bytes above the selected one are 0xFF when bit 7 of the inserted byte is 1, and 0x00 otherwise. Bytes below the selected one are always 0x00.
- R4: Unused format 0 (zero) and the reserved format 3 both clear every byte or word that is not selected.
- R5: Select code 4 writes new result bits [15:0] into output bits [15:0]. Select code 5 writes them into output bits [31:16], so select bit 0 picks the half.
- R6: In word mode the other half is handled by the format. With keep it is copied from the current destination. With sign-extend it is 0xFFFF when it lies above the written half and bit 15 of the inserted half is 1. In every other case it is zero.
- R7: Select code 6 writes the full 32-bit new result, whatever the format.
- R8: With `clamp_en` high, a new result above the field's unsigned maximum is replaced by that maximum: 0xFF for byte selects and 0xFFFF for word selects. Select 6 is not altered. Sign extension looks at the clamped value.
- R9: Select code 7 sets `sel_err_q` and makes the output equal to the current destination. All other codes clear `sel_err_q`.
- R10: Outputs are zero after reset. They update on the clock edge after a cycle with `in_en` high, and they hold while `in_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_en | input | 1 | Load enable for the output register |
| new_res | input | 32 | Newly computed result |
| cur_dst | input | 32 | Current destination register value |
| sel_code | input | 3 | Target: 0-3 byte, 4-5 half, 6 full, 7 reserved |
| unused_fmt | input | 2 | 0 zero, 1 sign-extend, 2 keep, 3 treated as zero |
| clamp_en | input | 1 | Saturate result to the field's unsigned range |
| merged_q | output | 32 | Merged destination word |
| sel_err_q | output | 1 | Reserved select code was seen |

## Verification
Clamping and sign extension can act on the same operation. A clamped overflow yields 0xFF or 0xFFFF, and that value has its top bit set, so it must drive the upward fill. The bench provokes this with an oversized result, a byte or half select, clamp high and sign-extend format. It expects ones above the field and zeros below it. It also runs the same oversized result with zero fill, and a small result under clamp, to show that clamping alone neither fills nor changes in-range values.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  typedef enum logic [1:0] {
    FMT_ZERO = 2'd0,
    FMT_SEXT = 2'd1,
    FMT_KEEP = 2'd2,
    FMT_RSVD = 2'd3
  } unused_fmt_e;

  localparam logic [2:0] SEL_FULL = 3'd6;
  localparam logic [2:0] SEL_BAD  = 3'd7;
endpackage

// File: rtl/sdm_field_sat.sv
module sdm_field_sat #(
  parameter int IN_W  = 32,
  parameter int OUT_W = 8
) (
  input  logic [IN_W-1:0]  val_i,
  input  logic             clamp_i,
  output logic [OUT_W-1:0] val_o
);
  generate
    if (OUT_W < IN_W) begin : g_sat
      logic over;
      always_comb begin
        over  = |val_i[IN_W-1:OUT_W];
        val_o = (clamp_i && over) ? {OUT_W{1'b1}} : val_i[OUT_W-1:0];
      end
    end else begin : g_pass
      logic unused_clamp;
      always_comb begin
        unused_clamp = clamp_i;
        val_o        = val_i[OUT_W-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/sdm_lane_merge.sv
module sdm_lane_merge
  import sdm_pkg::*;
#(
  parameter int DW = 32,
  parameter int FW = 8,
  localparam int NF    = DW / FW,
  localparam int IDX_W = (NF > 1) ? $clog2(NF) : 1
) (
  input  logic [FW-1:0]    field_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    cur_i,
  input  unused_fmt_e      fmt_i,
  output logic [DW-1:0]    word_o
);
  logic fill_ones;
  assign fill_ones = (fmt_i == FMT_SEXT) && field_i[FW-1];

  generate
    for (genvar f = 0; f < NF; f++) begin : g_field
      always_comb begin
        if (IDX_W'(f) == idx_i) begin
          word_o[f*FW +: FW] = field_i;
        end else if (fmt_i == FMT_KEEP) begin
          word_o[f*FW +: FW] = cur_i[f*FW +: FW];
        end else if ((IDX_W'(f) > idx_i) && fill_ones) begin
          word_o[f*FW +: FW] = {FW{1'b1}};
        end else begin
          word_o[f*FW +: FW] = '0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/sdm_merge_unit.sv
module sdm_merge_unit
  import sdm_pkg::*;
#(
  parameter int DW = 32,
  parameter int BW = 8,
  localparam int HW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_en,
  input  logic [DW-1:0] new_res,
  input  logic [DW-1:0] cur_dst,
  input  logic [2:0]    sel_code,
  input  logic [1:0]    unused_fmt,
  input  logic          clamp_en,
  output logic [DW-1:0] merged_q,
  output logic          sel_err_q
);
  localparam int NB  = DW / BW;
  localparam int NH  = DW / HW;
  localparam int BIW = (NB > 1) ? $clog2(NB) : 1;
  localparam int HIW = (NH > 1) ? $clog2(NH) : 1;

  unused_fmt_e   fmt;
  logic [BW-1:0] byte_val;
  logic [HW-1:0] half_val;
  logic [DW-1:0] byte_word, half_word;
  logic [DW-1:0] merged_d;
  logic          err_d;

  assign fmt = unused_fmt_e'(unused_fmt);

  sdm_field_sat #(.IN_W(DW), .OUT_W(BW)) u_sat_byte (
    .val_i(new_res), .clamp_i(clamp_en), .val_o(byte_val)
  );

  sdm_field_sat #(.IN_W(DW), .OUT_W(HW)) u_sat_half (
    .val_i(new_res), .clamp_i(clamp_en), .val_o(half_val)
  );

  sdm_lane_merge #(.DW(DW), .FW(BW)) u_byte_merge (
    .field_i(byte_val), .idx_i(sel_code[BIW-1:0]),
    .cur_i(cur_dst), .fmt_i(fmt), .word_o(byte_word)
  );

  sdm_lane_merge #(.DW(DW), .FW(HW)) u_half_merge (
    .field_i(half_val), .idx_i(sel_code[HIW-1:0]),
    .cur_i(cur_dst), .fmt_i(fmt), .word_o(half_word)
  );

  always_comb begin
    err_d    = 1'b0;
    merged_d = cur_dst;
    if (sel_code == SEL_BAD) begin
      err_d    = 1'b1;
      merged_d = cur_dst;
    end else if (sel_code == SEL_FULL) begin
      merged_d = new_res;
    end else if (sel_code[2]) begin
      merged_d = half_word;
    end else begin
      merged_d = byte_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      merged_q  <= '0;
      sel_err_q <= 1'b0;
    end else if (in_en) begin
      merged_q  <= merged_d;
      sel_err_q <= err_d;
    end
  end
endmodule

// File: rtl/sdm_merge_unit_chk.sv
module sdm_merge_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_en,
  input logic [31:0] new_res,
  input logic [31:0] cur_dst,
  input logic [2:0]  sel_code,
  input logic [1:0]  unused_fmt,
  input logic        clamp_en,
  input logic [31:0] merged_q,
  input logic        sel_err_q
);
  function automatic logic [31:0] byte_mask(input logic [1:0] idx);
    return 32'hFF << (8 * idx);
  endfunction

  function automatic logic [7:0] pick_byte(input logic [31:0] w, input logic [1:0] idx);
    return 8'(w >> (8 * idx));
  endfunction

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_en) |-> ($stable(merged_q) && $stable(sel_err_q)));

  assert_bad_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_en) && $past(sel_code) == 3'd7) |-> (sel_err_q && merged_q == $past(cur_dst)));

  assert_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_en) && $past(sel_code) != 3'd7) |-> !sel_err_q);

  assert_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_en) && $past(sel_code) == 3'd6) |-> merged_q == $past(new_res));

  assert_byte_ins_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_en) && !$past(sel_code[2]) && !$past(clamp_en))
      |-> pick_byte(merged_q, $past(sel_code[1:0])) == $past(new_res[7:0]));

  assert_byte_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_en) && !$past(sel_code[2]) && $past(unused_fmt) == 2'd2)
      |-> ((merged_q ^ $past(cur_dst)) & ~byte_mask($past(sel_code[1:0]))) == 32'h0);
endmodule

bind sdm_merge_unit sdm_merge_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_en(in_en), .new_res(new_res),
  .cur_dst(cur_dst), .sel_code(sel_code), .unused_fmt(unused_fmt),
  .clamp_en(clamp_en), .merged_q(merged_q), .sel_err_q(sel_err_q)
);

// File: tb/tb_sdm_merge_unit.sv
module tb_sdm_merge_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_en;
  logic [31:0] new_res, cur_dst;
  logic [2:0]  sel_code;
  logic [1:0]  unused_fmt;
  logic        clamp_en;
  logic [31:0] merged_q;
  logic        sel_err_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  sdm_merge_unit dut (
    .clk(clk), .rst_n(rst_n), .in_en(in_en), .new_res(new_res),
    .cur_dst(cur_dst), .sel_code(sel_code), .unused_fmt(unused_fmt),
    .clamp_en(clamp_en), .merged_q(merged_q), .sel_err_q(sel_err_q)
  );

  // res, cur, sel, fmt, clamp, expected word, expected error, tag
  localparam int NV = 17;
  localparam logic [102:0] VEC [NV] = '{
    {32'h12345678, 32'hAABBCCDD, 3'd0, 2'd0, 1'b0, 32'h00000078, 1'b0},
    {32'h12345678, 32'hAABBCCDD, 3'd2, 2'd2, 1'b0, 32'hAA78CCDD, 1'b0},
    {32'h000000F0, 32'hAABBCCDD, 3'd1, 2'd1, 1'b0, 32'hFFFFF000, 1'b0},
    {32'h00000070, 32'hAABBCCDD, 3'd1, 2'd1, 1'b0, 32'h00007000, 1'b0},
    {32'h00000081, 32'hAABBCCDD, 3'd3, 2'd3, 1'b0, 32'h81000000, 1'b0},
    {32'h00000080, 32'hAABBCCDD, 3'd0, 2'd1, 1'b0, 32'hFFFFFF80, 1'b0},
    {32'h1234ABCD, 32'hAABBCCDD, 3'd4, 2'd0, 1'b0, 32'h0000ABCD, 1'b0},
    {32'h1234ABCD, 32'hAABBCCDD, 3'd5, 2'd2, 1'b0, 32'hABCDCCDD, 1'b0},
    {32'h00008001, 32'hAABBCCDD, 3'd4, 2'd1, 1'b0, 32'hFFFF8001, 1'b0},
    {32'h00008001, 32'hAABBCCDD, 3'd5, 2'd1, 1'b0, 32'h80010000, 1'b0},
    {32'h12345678, 32'hAABBCCDD, 3'd6, 2'd2, 1'b0, 32'h12345678, 1'b0},
    {32'h00000123, 32'hAABBCCDD, 3'd1, 2'd0, 1'b1, 32'h0000FF00, 1'b0},
    {32'h00000123, 32'hAABBCCDD, 3'd1, 2'd1, 1'b1, 32'hFFFFFF00, 1'b0},
    {32'h00012345, 32'hAABBCCDD, 3'd4, 2'd0, 1'b1, 32'h0000FFFF, 1'b0},
    {32'h000000A5, 32'hAABBCCDD, 3'd1, 2'd0, 1'b1, 32'h0000A500, 1'b0},
    {32'hDEADBEEF, 32'hAABBCCDD, 3'd6, 2'd0, 1'b1, 32'hDEADBEEF, 1'b0},
    {32'h12345678, 32'hAABBCCDD, 3'd7, 2'd2, 1'b0, 32'hAABBCCDD, 1'b1}
  };
  localparam string TAG [NV] = '{
    "R1 R4", "R2", "R3", "R3", "R4", "R3", "R5 R4", "R5 R6", "R6", "R6",
    "R7", "R8", "R8", "R8", "R8", "R7 R8", "R9"
  };

  task automatic check(input string req, input logic [31:0] got_w, input logic got_e,
                       input logic [31:0] exp_w, input logic exp_e);
    n_chk++;
    if (got_w !== exp_w || got_e !== exp_e) begin
      n_bad++;
      $display("FAIL %s: got word=%h err=%b, expected word=%h err=%b",
               req, got_w, got_e, exp_w, exp_e);
    end
  endtask

  task automatic drive(input logic [31:0] r, input logic [31:0] c, input logic [2:0] s,
                       input logic [1:0] f, input logic cl, input logic en);
    @(negedge clk);
    new_res = r; cur_dst = c; sel_code = s; unused_fmt = f; clamp_en = cl; in_en = en;
    @(negedge clk);
    in_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_en = 1'b0; new_res = '0; cur_dst = '0;
    sel_code = '0; unused_fmt = '0; clamp_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset", merged_q, sel_err_q, 32'h0, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][102:71], VEC[i][70:39], VEC[i][38:36], VEC[i][35:34], VEC[i][33], 1'b1);
      check(TAG[i], merged_q, sel_err_q, VEC[i][32:1], VEC[i][0]);
    end

    // R10: hold while enable is low
    drive(32'h0000BEEF, 32'h11223344, 3'd6, 2'd0, 1'b0, 1'b1);
    drive(32'h55555555, 32'h66666666, 3'd7, 2'd0, 1'b0, 1'b0);
    check("R10 hold", merged_q, sel_err_q, 32'h0000BEEF, 1'b0);

    // R9: error clears on the next valid select
    drive(32'h0, 32'h01020304, 3'd7, 2'd0, 1'b0, 1'b1);
    check("R9 set", merged_q, sel_err_q, 32'h01020304, 1'b1);
    drive(32'h000000AB, 32'h01020304, 3'd3, 2'd2, 1'b0, 1'b1);
    check("R9 clear R2", merged_q, sel_err_q, 32'hAB020304, 1'b0);

    // R3: top byte selected, nothing above, lower bytes cleared
    drive(32'h000000FF, 32'hFFFFFFFF, 3'd3, 2'd1, 1'b0, 1'b1);
    check("R3 top", merged_q, sel_err_q, 32'hFF000000, 1'b0);

    // R8 with R6: clamped half is 0xFFFF, fills upper half
    drive(32'h7FFF0000, 32'h0, 3'd4, 2'd1, 1'b1, 1'b1);
    check("R8 R6", merged_q, sel_err_q, 32'hFFFFFFFF, 1'b0);

    // R10: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 async", merged_q, sel_err_q, 32'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule